// File: doc/BRIEF.md
# Bidirectional Latched Serial-to-Parallel Driver

This block holds the digital control of a 64-channel serial-in, parallel-out output driver. A chain of flops receives one bit on every rising clock edge. A direction input picks which end of the chain accepts data and which way the bits travel. Each end has a data pin that serves as input or output depending on that direction. The pins are modelled as separate input, output and output-enable signals, so a board-level tristate can be built around them.

A level-sensitive latch sits between the chain and the channel outputs. It is transparent while the latch enable is high and freezes when the enable falls, so a new pattern can be shifted in while the outputs hold the old one. Each latched bit then passes through a blanking gate and then a polarity stage. The serial output at the far end of the chain lets several devices be daisy-chained on one data line.

The serial interface has no valid/ready handshake. The chain takes one bit on every clock edge and never applies back-pressure, so an upstream source that cannot keep pace must stop the clock itself.

Top module: `ser2par_driver`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, the chain clears to all zeros on each clock edge and the latch holds all zeros. With `polarity`=1 and `blank_n`=1, every channel output is then 0.
- R2: With `dir`=0, each rising edge loads `end_a_in` into channel 64 (`chan_out[63]`), and every other channel k takes the old value of channel k+1.
- R3: With `dir`=1, each rising edge loads `end_b_in` into channel 1 (`chan_out[0]`), and every other channel k takes the old value of channel k-1.
- R4: With `dir`=0, `end_b_oe`=1, `end_a_oe`=0, `end_b_out` equals chain stage 1 and `end_a_out`=0. With `dir`=1, `end_a_oe`=1, `end_b_oe`=0, `end_a_out` equals chain stage 64 and `end_b_out`=0.
- R5: A bit presented on the active data input appears on the active serial output after exactly 64 rising edges, provided the direction does not change in between.
- R6: `latch_en`, `blank_n` and `polarity` never stall or alter the shifting of the chain.
- R7: While `latch_en` is high, the latch follows the chain contents.
- R8: While `latch_en` is low, the latch keeps the value it held when `latch_en` fell, even though the chain goes on shifting.
- R9: With `blank_n`=1, output k equals latched bit k when `polarity`=1, and the inverse of latched bit k when `polarity`=0.
- R10: With `blank_n`=0, every latched bit is forced to 0 before polarity is applied, so all outputs equal the inverse of `polarity`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | 0: A feeds, data moves 64 to 1; 1: B feeds, data moves 1 to 64 |
| end_a_in | input | 1 | Serial data arriving at end A |
| end_a_out | output | 1 | Serial data leaving through end A |
| end_a_oe | output | 1 | Drive enable for end A |
| end_b_in | input | 1 | Serial data arriving at end B |
| end_b_out | output | 1 | Serial data leaving through end B |
| end_b_oe | output | 1 | Drive enable for end B |
| latch_en | input | 1 | Latch transparent when high, holds when low |
| blank_n | input | 1 | Active-low blanking of all channels |
| polarity | input | 1 | 1: outputs follow data, 0: outputs inverted |
| chan_out | output | 64 | Channel outputs, bit 0 is channel 1 |

## Verification
The hardest situation to reach from the ports is the latch keeping an old pattern while the chain underneath shifts in a new one. The stimulus therefore loads a full pattern, pulses `latch_en` once, and then keeps shifting random data with the latch closed while it steps through every polarity and blanking combination. Cascade timing is the other hard case, because a direction change leaves stale bits in the chain. The bench tracks the serial stream in a queue and restarts that queue whenever the direction changes or reset is applied, so each comparison covers a full 64-edge trip in a single direction.

// File: rtl/drv_pkg.sv
package drv_pkg;
  typedef enum logic {
    SHIFT_DOWN = 1'b0,
    SHIFT_UP   = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/drv_shift_chain.sv
module drv_shift_chain
  import drv_pkg::*;
#(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  shift_dir_e   dir,
  input  logic         a_in,
  input  logic         b_in,
  output logic [N-1:0] stages
);
  logic [N-1:0] sr_q;

  // Index 0 is channel 1, index N-1 is channel N.
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (dir == SHIFT_DOWN) begin
      sr_q <= {a_in, sr_q[N-1:1]};
    end else begin
      sr_q <= {sr_q[N-2:0], b_in};
    end
  end

  assign stages = sr_q;

  // R2: downward shift, A enters at the top channel
  a_r2_shift_down: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dir) == SHIFT_DOWN) |->
      (sr_q[N-2:0] == $past(sr_q[N-1:1]) && sr_q[N-1] == $past(a_in)));

  // R3: upward shift, B enters at channel 1
  a_r3_shift_up: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dir) == SHIFT_UP) |->
      (sr_q[N-1:1] == $past(sr_q[N-2:0]) && sr_q[0] == $past(b_in)));
endmodule

// File: rtl/drv_hold_latch.sv
module drv_hold_latch #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] lat;

  always_latch begin
    if (rst) begin
      lat = '0;
    end else if (le) begin
      lat = d;
    end
  end

  assign q = lat;

  // R7: transparent while enable is high
  a_r7_transparent: assert property (@(posedge clk) disable iff (rst)
    le |-> (q == d));

  // R8: frozen while enable stays low
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!le && !$past(le) && !$past(rst)) |-> $stable(q));
endmodule

// File: rtl/drv_out_gate.sv
module drv_out_gate #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         blank_n,
  input  logic         pol,
  input  logic [N-1:0] held,
  output logic [N-1:0] ch
);
  for (genvar k = 0; k < N; k++) begin : g_chan
    logic gated;
    assign gated = held[k] & blank_n;
    assign ch[k] = pol ? gated : ~gated;
  end

  // R10: blanking puts every channel at the inactive level
  a_r10_blank: assert property (@(posedge clk) disable iff (rst)
    !blank_n |-> (ch == {N{~pol}}));

  // R9: polarity selects true or inverted data when not blanked
  a_r9_polarity: assert property (@(posedge clk) disable iff (rst)
    blank_n |-> (ch == (pol ? held : ~held)));
endmodule

// File: rtl/ser2par_driver.sv
module ser2par_driver
  import drv_pkg::*;
#(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir,
  input  logic         end_a_in,
  output logic         end_a_out,
  output logic         end_a_oe,
  input  logic         end_b_in,
  output logic         end_b_out,
  output logic         end_b_oe,
  input  logic         latch_en,
  input  logic         blank_n,
  input  logic         polarity,
  output logic [N-1:0] chan_out
);
  localparam int TOP = N - 1;

  shift_dir_e   dir_e;
  logic [N-1:0] stages;
  logic [N-1:0] held;

  assign dir_e = shift_dir_e'(dir);

  drv_shift_chain #(.N(N)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .dir    (dir_e),
    .a_in   (end_a_in),
    .b_in   (end_b_in),
    .stages (stages)
  );

  drv_hold_latch #(.N(N)) u_latch (
    .clk (clk),
    .rst (rst),
    .le  (latch_en),
    .d   (stages),
    .q   (held)
  );

  drv_out_gate #(.N(N)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .blank_n (blank_n),
    .pol     (polarity),
    .held    (held),
    .ch      (chan_out)
  );

  // The end that is not receiving drives the last stage of the chain.
  always_comb begin
    end_a_oe  = (dir_e == SHIFT_UP);
    end_b_oe  = (dir_e == SHIFT_DOWN);
    end_a_out = end_a_oe ? stages[TOP] : 1'b0;
    end_b_out = end_b_oe ? stages[0]   : 1'b0;
  end

  // R5: bit leaving through B was at channel 2 one edge earlier
  a_r5_cascade_down: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dir) && !dir) |-> (end_b_out == $past(chan_out[1] ^ ~polarity)
      || !$past(latch_en) || !$past(blank_n) || $past(polarity) != polarity || !latch_en));
endmodule

// File: tb/ser2par_driver_tb_top.sv
`timescale 1ns/1ps
module ser2par_driver_tb_top;
  localparam int N = 64;

  logic clk = 0;
  logic rst = 1, dir = 0, a_in = 0, b_in = 0, le = 1, blank_n = 1, pol = 1;
  logic a_out, a_oe, b_out, b_oe;
  logic [N-1:0] chan;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  ser2par_driver #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .dir(dir),
    .end_a_in(a_in), .end_a_out(a_out), .end_a_oe(a_oe),
    .end_b_in(b_in), .end_b_out(b_out), .end_b_oe(b_oe),
    .latch_en(le), .blank_n(blank_n), .polarity(pol),
    .chan_out(chan)
  );

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference: channels numbered 1..64.
  logic m [1:N];
  logic lm [1:N];
  logic q [$];
  logic last_dir = 0;

  initial for (int k = 1; k <= N; k++) begin m[k] = 0; lm[k] = 0; end

  always @(posedge clk) begin
    logic [N-1:0] exp_ch;
    logic fed;
    fed = dir ? b_in : a_in;
    if (rst) begin
      for (int k = 1; k <= N; k++) m[k] = 0;
    end else if (!dir) begin
      for (int k = 1; k < N; k++) m[k] = m[k+1];
      m[N] = a_in;
    end else begin
      for (int k = N; k > 1; k--) m[k] = m[k-1];
      m[1] = b_in;
    end
    if (rst || dir != last_dir) q.delete();
    if (!rst) q.push_back(fed);
    last_dir = dir;
    #2;
    if (rst) for (int k = 1; k <= N; k++) lm[k] = 0;
    else if (le) for (int k = 1; k <= N; k++) lm[k] = m[k];
    for (int k = 1; k <= N; k++) begin
      logic g;
      g = lm[k] & blank_n;
      exp_ch[k-1] = pol ? g : ~g;
    end
    // R1 R6 R7 R8 R9 R10 channel outputs after every edge
    check("R1/R7/R8/R9/R10 channels", chan, exp_ch);
    // R2 R3 R4 serial ends and enables
    check("R4 oe", {{(N-2){1'b0}}, a_oe, b_oe}, {{(N-2){1'b0}}, dir, ~dir});
    check("R2/R3/R4 serial out", {{(N-2){1'b0}}, a_out, b_out},
          {{(N-2){1'b0}}, dir ? m[N] : 1'b0, dir ? 1'b0 : m[1]});
    if (q.size() == N) begin
      // R5 cascade latency of exactly N edges
      check("R5 cascade", {{(N-1){1'b0}}, dir ? a_out : b_out}, {{(N-1){1'b0}}, q[0]});
      void'(q.pop_front());
    end
  end

  task automatic step(input int n, input logic rnd_ctl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      a_in = 1'($urandom);
      b_in = 1'($urandom);
      if (rnd_ctl) begin // R6: control inputs toggle while shifting
        pol = 1'($urandom);
        blank_n = 1'($urandom);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    le = 0;
    // R2: full load downward with controls toggling
    step(N, 1);
    @(negedge clk); pol = 1; blank_n = 1; le = 1;
    @(negedge clk); le = 0;
    // R8: hold while shifting, all combinations
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); pol = c[0]; blank_n = c[1];
      step(6, 0);
    end
    step(70, 0);
    // R3: full load upward, latch open half the time
    @(negedge clk); dir = 1;
    step(N + 10, 1);
    le = 1;
    step(40, 0);
    le = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); pol = c[0]; blank_n = c[1];
      step(5, 0);
    end
    // R1: reset mid-run with latch open
    @(negedge clk); le = 1; pol = 1; blank_n = 1; rst = 1;
    step(3, 0);
    @(negedge clk); rst = 0;
    // mixed random traffic
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (i % 97 == 50) dir = ~dir;
      le = ($urandom % 8) == 0;
      step(1, 1);
    end
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20000 * 10);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule